// File: doc/BRIEF.md
# Extended Match Timer Channels

This block holds eight extended match channels, numbered 4 to 11, for a chip-level operating-system timer. Each channel owns a 32-bit up-counter, a 32-bit compare value and a 10-bit control word. A channel compares either against its own private counter or against the counter of its group leader. Counter 4 leads channels 4 to 7, counter 8 leads channels 8 and 9, and counter 10 leads channels 10 and 11. Each counter advances on single-cycle tick pulses of one of five rates. The rate is chosen per counter by its control word.

A match happens when a tick carries the compared counter onto the compare value. The match can clear that counter, and it either disarms the channel or leaves it armed for more matches. The match also sets the channel's bit in a status vector when the channel's interrupt enable is set. The status vector and a combined interrupt come out on ports. The enables come in from outside, because this storage is shared with a base timer. Reading counter 9 or counter 11 can also capture the current value of its leader into a snapshot register.

Software reaches the block over a simple word-addressed register bus. Writes complete in one cycle. Read data is combinational from the address.

Top module: `tmx_ext_timer`

## Requirements
- R1: After reset, every counter, compare value, control word and the snapshot read as 0, and status and the combined interrupt are 0. The reset is asynchronous, and its release takes effect synchronously.
- R2: Control bits 2:0 pick the counter's tick input. Code 1 uses `rate_tick_i[0]` (32.768 kHz), code 2 uses bit 1 (1 kHz), code 3 uses bit 2 (1 Hz), code 4 uses bit 3 (1 MHz) and code 5 uses bit 4 (external). The counter increments once per pulse of the selected bit and ignores the other bits.
- R3: Codes 0, 6 and 7 stop the counter, which then holds its value. A bus write to a stopped counter still loads the new value.
- R4: Control bit 7 set makes a channel compare against its own counter. With bit 7 clear, channels 4–7 compare against counter 4, channels 8–9 against counter 8, and channels 10–11 against counter 10. Counters 4, 8 and 10 always apply their own rate code. Any other counter with bit 7 clear never advances.
- R5: A control write stores bits 7:0 for channels 4–7 and bits 9:0 for channels 8–11. All other bits read back as 0.
- R6: For channels 8–11, control bit 8 set stops the counter whatever bits 2:0 hold.
- R7: Control bit 3 set clears the compared counter on a match. The counter reads 0 instead of the compare value.
- R8: A write to a channel's compare register or to its own counter arms the channel. With control bit 6 set, the channel stays armed after a match. With bit 6 clear, the channel fires once and then stays quiet until it is rearmed.
- R9: An armed channel matches in the cycle where a tick takes its compared counter from one value to its compare value. Status bit (n−4) is then set, but only when `irq_en_i[n−4]` is 1. With the enable clear, the status is untouched.
- R10: `grp_irq_o` rises in the same cycle as the first status bit. It stays high until a `stat_clr_i` pulse leaves all status bits zero. Clearing one of two set bits keeps it high.
- R11: A read of counter 9 while control 9 bit 9 is set copies counter 8 into the snapshot. A read of counter 11 while control 11 bit 9 is set copies counter 10 into the snapshot. Other reads leave the snapshot unchanged.
- R12: Counter n sits at 0x40+4·(n−4), compare n at 0x80+4·(n−4), control n at 0xC0+4·(n−4), and the snapshot at 0x20. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the snapshot capture) |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address |
| rate_tick_i | input | 5 | Single-cycle rate pulses: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| irq_en_i | input | 8 | Shared interrupt enables for channels 4–11 |
| stat_clr_i | input | 8 | Write-one-to-clear pulse for the status bits |
| stat_o | output | 8 | Status bits for channels 4–11 |
| grp_irq_o | output | 1 | Combined interrupt |

## Verification
The bench checks that a follower channel compares against its leader's counter, while its private counter sits still unless control bit 7 is set. A design that muxed the wrong counter would match at the wrong time or never. The bench drives every rate code and then the off-codes. A mis-decoded rate shows up as a counter that moves on the wrong pulse or holds when it should count. The bench contrasts one-shot with periodic rearm and reset-on-match. A design that failed to disarm would set status a second time, and one that cleared the wrong counter would read the compare value back. The snapshot is exercised with the capture bit both clear and set, and the interrupt is cleared one status bit at a time, so an early drop of the combined line is caught.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
  localparam int unsigned NCH       = 8;
  localparam int unsigned CH_W      = $clog2(NCH);
  localparam int unsigned CTRL_W    = 10;
  localparam int unsigned RATE_N    = 5;
  localparam int unsigned WIDE_FROM = 4;  // index of channel 8: wide control from here on

  // control word bit positions
  localparam int unsigned CB_OWN    = 7;
  localparam int unsigned CB_REARM  = 6;
  localparam int unsigned CB_ZERO   = 3;
  localparam int unsigned CB_FREEZE = 8;
  localparam int unsigned CB_SNAP   = 9;

  // counter group leaders, as channel index (channel number minus 4)
  localparam logic [CH_W-1:0] LEAD_A = CH_W'(0);
  localparam logic [CH_W-1:0] LEAD_B = CH_W'(4);
  localparam logic [CH_W-1:0] LEAD_C = CH_W'(6);

  typedef enum logic [2:0] {
    RATE_OFF  = 3'd0,
    RATE_32K  = 3'd1,
    RATE_1K   = 3'd2,
    RATE_1HZ  = 3'd3,
    RATE_1M   = 3'd4,
    RATE_EXT  = 3'd5
  } rate_e;

  function automatic logic [CH_W-1:0] leader_of(input int unsigned k);
    if (k < 4)      return LEAD_A;
    else if (k < 6) return LEAD_B;
    else            return LEAD_C;
  endfunction

  function automatic bit is_leader(input int unsigned k);
    return (k == 0) || (k == 4) || (k == 6);
  endfunction
endpackage

// File: rtl/tmx_regbank.sv
module tmx_regbank
  import tmx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [NCH-1:0][DATA_W-1:0]     cnt_i,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [NCH-1:0][DATA_W-1:0]     match_o,
  output logic [NCH-1:0][2:0]            rate_o,
  output logic [NCH-1:0]                 own_o,
  output logic [NCH-1:0]                 zero_o,
  output logic [NCH-1:0]                 rearm_o,
  output logic [NCH-1:0]                 freeze_o,
  output logic [NCH-1:0]                 cnt_wr_o,
  output logic [NCH-1:0]                 match_wr_o
);
  localparam logic [2:0] RG_CNT = 3'b010;
  localparam logic [2:0] RG_MAT = 3'b100;
  localparam logic [2:0] RG_CTL = 3'b110;
  localparam logic [7:0] SNAP_OFS = 8'h20;
  // snapshot pairs: reading channel 9 captures 8, channel 11 captures 10
  localparam logic [CH_W-1:0] SNAP_RD_A = CH_W'(5);
  localparam logic [CH_W-1:0] SNAP_RD_B = CH_W'(7);

  logic [NCH-1:0][CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NCH-1:0][DATA_W-1:0] match_q, match_d;
  logic [DATA_W-1:0]          snap_q, snap_d;

  logic            in_page, aligned;
  logic [2:0]      region;
  logic [CH_W-1:0] idx;
  logic            cnt_sel, mat_sel, ctl_sel, snap_sel;

  assign in_page  = (bus_addr[ADDR_W-1:8] == '0);
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign region   = bus_addr[7:5];
  assign idx      = bus_addr[4:2];
  assign cnt_sel  = in_page && aligned && (region == RG_CNT);
  assign mat_sel  = in_page && aligned && (region == RG_MAT);
  assign ctl_sel  = in_page && aligned && (region == RG_CTL);
  assign snap_sel = in_page && (bus_addr[7:0] == SNAP_OFS);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [CTRL_W-1:0] KEEP = (k >= WIDE_FROM) ? 10'h3FF : 10'h0FF;
    logic hit_here;
    assign hit_here = (idx == CH_W'(k));

    always_comb begin
      ctrl_d[k] = ctrl_q[k];
      if (bus_wr && ctl_sel && hit_here) ctrl_d[k] = bus_wdata[CTRL_W-1:0] & KEEP;
    end

    always_comb begin
      match_d[k] = match_q[k];
      if (bus_wr && mat_sel && hit_here) match_d[k] = bus_wdata;
    end

    assign cnt_wr_o[k]   = bus_wr && cnt_sel && hit_here;
    assign match_wr_o[k] = bus_wr && mat_sel && hit_here;
    assign rate_o[k]     = ctrl_q[k][2:0];
    assign own_o[k]      = ctrl_q[k][CB_OWN];
    assign zero_o[k]     = ctrl_q[k][CB_ZERO];
    assign rearm_o[k]    = ctrl_q[k][CB_REARM];
    if (k >= WIDE_FROM) begin : g_wide
      assign freeze_o[k] = ctrl_q[k][CB_FREEZE];
    end else begin : g_narrow
      assign freeze_o[k] = 1'b0;
    end
  end

  always_comb begin
    snap_d = snap_q;
    if (bus_rd && cnt_sel) begin
      if (idx == SNAP_RD_A && ctrl_q[SNAP_RD_A][CB_SNAP])      snap_d = cnt_i[LEAD_B];
      else if (idx == SNAP_RD_B && ctrl_q[SNAP_RD_B][CB_SNAP]) snap_d = cnt_i[LEAD_C];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      match_q <= '0;
      snap_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      match_q <= match_d;
      snap_q  <= snap_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (cnt_sel)       bus_rdata = cnt_i[idx];
    else if (mat_sel)  bus_rdata = match_q[idx];
    else if (ctl_sel)  bus_rdata = DATA_W'(ctrl_q[idx]);
    else if (snap_sel) bus_rdata = snap_q;
  end

  assign match_o = match_q;
endmodule

// File: rtl/tmx_rate_pick.sv
module tmx_rate_pick
  import tmx_pkg::*;
#(
  parameter bit LEADER = 1'b0
) (
  input  logic [2:0]        rate_code,
  input  logic              own,
  input  logic              freeze,
  input  logic [RATE_N-1:0] rate_tick,
  output logic              adv
);
  logic run;
  assign run = (own || LEADER) && !freeze;

  always_comb begin
    adv = 1'b0;
    if (run) begin
      case (rate_e'(rate_code))
        RATE_32K: adv = rate_tick[0];
        RATE_1K:  adv = rate_tick[1];
        RATE_1HZ: adv = rate_tick[2];
        RATE_1M:  adv = rate_tick[3];
        RATE_EXT: adv = rate_tick[4];
        default:  adv = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tmx_counter.sv
module tmx_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (clr) cnt_d = '0;
    else if (adv) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmx_match_unit.sv
module tmx_match_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] src_cnt,
  input  logic         src_adv,
  input  logic [W-1:0] match_val,
  input  logic         rearm,
  output logic         hit_o
);
  logic armed_q, armed_d;

  assign hit_o = armed_q && src_adv && ((src_cnt + W'(1)) == match_val);

  always_comb begin
    armed_d = armed_q;
    if (arm)                 armed_d = 1'b1;
    else if (hit_o && !rearm) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/tmx_ext_timer.sv
module tmx_ext_timer
  import tmx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [RATE_N-1:0] rate_tick_i,
  input  logic [NCH-1:0]    irq_en_i,
  input  logic [NCH-1:0]    stat_clr_i,
  output logic [NCH-1:0]    stat_o,
  output logic              grp_irq_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NCH-1:0][DATA_W-1:0] cnt, match, src_cnt;
  logic [NCH-1:0][2:0]        rate;
  logic [NCH-1:0]             own, zero, rearm, freeze;
  logic [NCH-1:0]             cnt_wr, match_wr;
  logic [NCH-1:0]             adv_raw, adv_eff, src_adv, hit, clr_req;
  logic [NCH-1:0][CH_W-1:0]   src_idx;

  tmx_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cnt_i      (cnt),
    .bus_rdata  (bus_rdata),
    .match_o    (match),
    .rate_o     (rate),
    .own_o      (own),
    .zero_o     (zero),
    .rearm_o    (rearm),
    .freeze_o   (freeze),
    .cnt_wr_o   (cnt_wr),
    .match_wr_o (match_wr)
  );

  for (genvar j = 0; j < NCH; j++) begin : g_cnt
    tmx_rate_pick #(.LEADER(is_leader(j))) u_rate (
      .rate_code (rate[j]),
      .own       (own[j]),
      .freeze    (freeze[j]),
      .rate_tick (rate_tick_i),
      .adv       (adv_raw[j])
    );

    // a bus load in the same cycle wins over a tick and suppresses matching on it
    assign adv_eff[j] = adv_raw[j] && !cnt_wr[j];

    tmx_counter #(.W(DATA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .adv      (adv_eff[j]),
      .load     (cnt_wr[j]),
      .load_val (bus_wdata),
      .clr      (clr_req[j]),
      .cnt_o    (cnt[j])
    );
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign src_idx[k] = own[k] ? CH_W'(k) : leader_of(k);
    assign src_cnt[k] = cnt[src_idx[k]];
    assign src_adv[k] = adv_eff[src_idx[k]];

    tmx_match_unit #(.W(DATA_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .arm       (match_wr[k] || cnt_wr[k]),
      .src_cnt   (src_cnt[k]),
      .src_adv   (src_adv[k]),
      .match_val (match[k]),
      .rearm     (rearm[k]),
      .hit_o     (hit[k])
    );
  end

  // reset-on-match targets whichever counter the matching channel compares against
  always_comb begin
    clr_req = '0;
    for (int k = 0; k < NCH; k++) begin
      if (hit[k] && zero[k]) clr_req[src_idx[k]] = 1'b1;
    end
  end

  logic [NCH-1:0] stat_q, stat_d;
  logic           irq_q, irq_d;

  always_comb begin
    stat_d = (stat_q & ~stat_clr_i) | (hit & irq_en_i);
    irq_d  = |stat_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_o    = stat_q;
  assign grp_irq_o = irq_q;
endmodule

// File: rtl/tmx_ext_timer_chk.sv
module tmx_ext_timer_chk
  import tmx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [RATE_N-1:0] rate_tick_i,
  input logic [NCH-1:0]    irq_en_i,
  input logic [NCH-1:0]    stat_clr_i,
  input logic [NCH-1:0]    stat_o,
  input logic              grp_irq_o
);
  logic rd_ctl_narrow, rd_ctl_wide, rd_snap;
  assign rd_ctl_narrow = bus_rd && (bus_addr >= ADDR_W'(12'h0C0)) && (bus_addr <= ADDR_W'(12'h0CC));
  assign rd_ctl_wide   = bus_rd && (bus_addr >= ADDR_W'(12'h0D0)) && (bus_addr <= ADDR_W'(12'h0DC));
  assign rd_snap       = bus_rd && (bus_addr == ADDR_W'(12'h020));

  // R5: stored control width per channel group
  a_r5_ctrl_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl_narrow |-> (bus_rdata[DATA_W-1:8] == '0)) else $error("a_r5_ctrl_narrow");
  a_r5_ctrl_wide: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl_wide |-> (bus_rdata[DATA_W-1:10] == '0)) else $error("a_r5_ctrl_wide");

  // R10: the combined line only falls after a clear request
  a_r10_irq_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grp_irq_o) |-> $past(|stat_clr_i)) else $error("a_r10_irq_drop_needs_clear");

  // R11: back-to-back snapshot reads see the same value
  a_r11_snap_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_snap && $past(rd_snap)) |-> (bus_rdata == $past(bus_rdata))) else $error("a_r11_snap_steady");

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    // R9: a status bit is only set through its enable
    a_r9_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[i]) |-> $past(irq_en_i[i])) else $error("a_r9_status_needs_enable");
    // R2: matches only occur on a rate pulse
    a_r2_status_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[i]) |-> $past(|rate_tick_i)) else $error("a_r2_status_needs_tick");
  end
endmodule

bind tmx_ext_timer tmx_ext_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .rate_tick_i (rate_tick_i),
  .irq_en_i    (irq_en_i),
  .stat_clr_i  (stat_clr_i),
  .stat_o      (stat_o),
  .grp_irq_o   (grp_irq_o)
);

// File: tb/tmx_ext_timer_tb.sv
`timescale 1ns/100ps
module tmx_ext_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  rate_tick = '0;
  logic [7:0]  irq_en = '0, stat_clr = '0;
  logic [7:0]  stat_o;
  logic        grp_irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  tmx_ext_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rate_tick_i(rate_tick), .irq_en_i(irq_en), .stat_clr_i(stat_clr),
    .stat_o(stat_o), .grp_irq_o(grp_irq_o)
  );

  // monitor: pops an expected read value for every read cycle
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1 bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic pulse(input int b, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 rate_tick[b] = 1'b1;
      @(posedge clk); #1 rate_tick = '0;
    end
  endtask

  task automatic clr(input logic [7:0] m);
    @(posedge clk); #1 stat_clr = m;
    @(posedge clk); #1 stat_clr = '0;
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    rd(12'h040, 32'h0, "R1 cnt4");
    rd(12'h09C, 32'h0, "R1 match11");
    rd(12'h0C0, 32'h0, "R1 ctrl4");
    rd(12'h0DC, 32'h0, "R1 ctrl11");
    rd(12'h020, 32'h0, "R1 snap");
    chk("R1 stat", 32'(stat_o), 32'h0);
    chk("R1 irq", 32'(grp_irq_o), 32'h0);

    // R12 map
    rd(12'h024, 32'h0, "R12 unmapped");
    wr(12'h09C, 32'h55);
    rd(12'h09C, 32'h55, "R12 match11 at 0x9C");

    // R2 rate selection
    wr(12'h0C0, 32'h1);
    pulse(0, 5);
    rd(12'h040, 32'd5, "R2 32k x5");
    pulse(1, 3);
    rd(12'h040, 32'd5, "R2 other rate ignored");
    wr(12'h0C0, 32'h2); pulse(1, 2);
    rd(12'h040, 32'd7, "R2 1k");
    wr(12'h0C0, 32'h3); pulse(2, 1);
    rd(12'h040, 32'd8, "R2 1Hz");
    wr(12'h0C0, 32'h4); pulse(3, 1);
    rd(12'h040, 32'd9, "R2 1MHz");
    wr(12'h0C0, 32'h5); pulse(4, 1);
    rd(12'h040, 32'd10, "R2 ext");
    pulse(0, 2);
    rd(12'h040, 32'd10, "R2 32k ignored on ext");

    // R3 stopped codes
    wr(12'h0C0, 32'h0);
    for (int b = 0; b < 5; b++) pulse(b, 1);
    rd(12'h040, 32'd10, "R3 code0 holds");
    wr(12'h0C0, 32'h6);
    for (int b = 0; b < 5; b++) pulse(b, 1);
    rd(12'h040, 32'd10, "R3 code6 holds");
    wr(12'h040, 32'd100);
    rd(12'h040, 32'd100, "R3 load while stopped");

    // R4 private counter of a follower
    wr(12'h0C4, 32'h01); pulse(0, 3);
    rd(12'h044, 32'd0, "R4 follower private stopped");
    wr(12'h0C4, 32'h81); pulse(0, 3);
    rd(12'h044, 32'd3, "R4 own counter runs");

    // R5 control widths
    wr(12'h0C0, 32'hFFFF_FFFF);
    rd(12'h0C0, 32'h0000_00FF, "R5 narrow ctrl4");
    wr(12'h0D0, 32'hFFFF_FFFF);
    rd(12'h0D0, 32'h0000_03FF, "R5 wide ctrl8");
    wr(12'h0C0, 32'h0);
    wr(12'h0D0, 32'h0);

    // R6 freeze bit on counter 8
    wr(12'h050, 32'h0);
    wr(12'h0D0, 32'h101); pulse(0, 3);
    rd(12'h050, 32'd0, "R6 freeze stops");
    wr(12'h0D0, 32'h001); pulse(0, 3);
    rd(12'h050, 32'd3, "R6 runs without freeze");
    wr(12'h0D0, 32'h0);

    // R4/R9 channel 6 compares against counter 4
    irq_en = 8'h04;
    wr(12'h0C0, 32'h04);
    wr(12'h040, 32'h0);
    wr(12'h0C8, 32'h00);
    wr(12'h088, 32'd2);
    pulse(3, 1);
    chk("R9 no match before value", 32'(stat_o), 32'h0);
    pulse(3, 1);
    chk("R4 shared compare stat", 32'(stat_o), 32'h04);
    chk("R10 irq raised", 32'(grp_irq_o), 32'h1);
    clr(8'h04);
    chk("R10 irq dropped", 32'(grp_irq_o), 32'h0);

    // R9 enable clear: no status
    irq_en = 8'h00;
    wr(12'h040, 32'h0);
    wr(12'h088, 32'd2);
    pulse(3, 2);
    chk("R9 disabled stat", 32'(stat_o), 32'h0);
    chk("R9 disabled irq", 32'(grp_irq_o), 32'h0);

    // R7/R8 periodic with reset on match
    irq_en = 8'h01;
    wr(12'h0C0, 32'h4C);
    wr(12'h080, 32'd3);
    wr(12'h040, 32'h0);
    pulse(3, 3);
    chk("R8 periodic first", 32'(stat_o), 32'h01);
    rd(12'h040, 32'd0, "R7 cleared on match");
    clr(8'h01);
    pulse(3, 3);
    chk("R8 periodic again", 32'(stat_o), 32'h01);
    rd(12'h040, 32'd0, "R7 cleared again");
    clr(8'h01);

    // R8 one-shot
    wr(12'h0C0, 32'h0C);
    wr(12'h080, 32'd3);
    wr(12'h040, 32'h0);
    pulse(3, 3);
    chk("R8 one-shot fires", 32'(stat_o), 32'h01);
    rd(12'h040, 32'd0, "R7 one-shot clear");
    clr(8'h01);
    pulse(3, 3);
    chk("R8 one-shot quiet", 32'(stat_o), 32'h0);
    rd(12'h040, 32'd3, "R7 no clear when disarmed");

    // R10 two sources
    wr(12'h0C4, 32'h84); wr(12'h044, 32'h0); wr(12'h084, 32'd1);
    wr(12'h0C0, 32'h04); wr(12'h040, 32'h0); wr(12'h080, 32'd1);
    irq_en = 8'h03;
    pulse(3, 1);
    chk("R10 both set", 32'(stat_o), 32'h03);
    chk("R10 irq on", 32'(grp_irq_o), 32'h1);
    clr(8'h01);
    chk("R10 partial clear stat", 32'(stat_o), 32'h02);
    chk("R10 irq held", 32'(grp_irq_o), 32'h1);
    clr(8'h02);
    chk("R10 irq off", 32'(grp_irq_o), 32'h0);

    // R11 snapshot
    wr(12'h0D0, 32'h001);
    wr(12'h050, 32'h1234);
    pulse(0, 2);
    wr(12'h0D0, 32'h000);
    wr(12'h0D4, 32'h200);
    rd(12'h054, 32'h0, "R11 cnt9 private");
    rd(12'h020, 32'h1236, "R11 snap of counter 8");
    wr(12'h058, 32'hABCD);
    rd(12'h05C, 32'h0, "R11 cnt11 private");
    rd(12'h020, 32'h1236, "R11 no capture without bit9");
    wr(12'h0DC, 32'h200);
    rd(12'h05C, 32'h0, "R11 cnt11 read");
    rd(12'h020, 32'hABCD, "R11 snap of counter 10");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule